// File: doc/BRIEF.md
# Serial Line Code Encoder/Decoder

This block sits between a serial channel and the wire. It turns a stream of data bits into a line level under one of seven run-time selectable codes. It also turns a sampled line back into data bits. The transmit and receive halves are independent and run at the same time, and each has its own 3-bit code select. Both halves are paced by half-bit strobes: an enable that pulses twice per bit time. At the top clock rate the enable can stay high on every cycle, so each half-bit takes one clock.

The transmit side takes one bit per bit time through a valid/ready pair. Ready is offered only on the strobe that starts a bit. When no bit is offered there, the line holds its level until the next bit-start strobe, which means the sender is back-pressured by the strobe pacing. The receive side is given a line that is already bit-aligned. Its first strobe after reset or after a code change is the first half of a bit. It emits one decoded bit, with a code-violation flag, after every second strobe. A wire cannot be stalled, so the receive output has no ready signal, and the consumer must take each pulse in the cycle it appears.

Top module: `lc_codec`

## Requirements
- R1: After reset, and in the cycle after any change of `tx_mode`, `tx_line` is 1 and the encoder restarts at a bit start. A change of `rx_mode` likewise restarts the decoder at a first half, with the previous-bit line level taken as 1.
- R2: `tx_ready` is high only in a cycle where `tx_half_en` is high, the encoder is at a bit start, and `tx_mode` is unchanged. A bit is taken when `tx_valid` and `tx_ready` are both high. `tx_line` changes only after a clock with `tx_half_en` high, or after a mode change. A bit-start strobe without `tx_valid` leaves the line unchanged.
- R3: Codes 0 (NRZ) and 7 (reserved) drive the data bit for both halves. Code 1 (inverted NRZ) drives its complement for both halves.
- R4: Code 2 inverts the line for a 1 and keeps it for a 0. Code 3 inverts the line for a 0 and keeps it for a 1. The same level is held for both halves.
- R5: Codes 4 and 5 invert the line at every bit start. Code 4 inverts it again mid-bit for a 1, and code 5 does so for a 0.
- R6: Code 6 drives 1 then 0 for a data 1, and 0 then 1 for a data 0.
- R7: `rx_valid` pulses for one cycle, in the cycle after every second `rx_half_en` strobe, and never on two cycles in a row. `rx_data` inverts the matching encoding rule of R3 to R6, using the first-half sample, the second-half sample and the previous bit's second-half level.
- R8: `rx_viol` can be high only together with `rx_valid` and only in codes 4 to 6. In codes 4 and 5 it flags a first half equal to the previous level. In code 6 it flags two equal halves.
- R9: Changing the code of one direction does not disturb the other direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tx_mode | input | 3 | Transmit code select |
| tx_half_en | input | 1 | Transmit half-bit strobe |
| tx_valid | input | 1 | Transmit bit offered |
| tx_data | input | 1 | Transmit bit value |
| tx_ready | output | 1 | Transmit bit taken this cycle when valid |
| tx_line | output | 1 | Coded line level |
| rx_mode | input | 3 | Receive code select |
| rx_half_en | input | 1 | Receive half-bit sampling strobe |
| rx_line | input | 1 | Sampled line level |
| rx_valid | output | 1 | Decoded bit pulse |
| rx_data | output | 1 | Decoded bit value |
| rx_viol | output | 1 | Code violation with this bit |

## Verification
A wrong transmit half-phase or a stale previous-level register shows at `tx_line` within one strobe. Once that happens, every later level in the differential codes is inverted, and the comparison with the bench model fails at the next half-bit. On the receive side, a bad phase moves the `rx_valid` pulse by one strobe, so it lands on a first-half strobe. A wrong previous-level value shows on the next decoded bit, as a wrong NRZI value or as a false or missing violation in the biphase codes. Mode changes at bit starts and in the middle of a bit check that the restart reaches both the level and the phase in the following cycle.

// File: rtl/lc_pkg.sv
package lc_pkg;
  localparam int MODE_W = 3;

  typedef enum logic [MODE_W-1:0] {
    LC_NRZ    = 3'd0,
    LC_NRZB   = 3'd1,
    LC_NRZI_M = 3'd2,
    LC_NRZI_S = 3'd3,
    LC_FM1    = 3'd4,
    LC_FM0    = 3'd5,
    LC_MANCH  = 3'd6,
    LC_RSVD   = 3'd7
  } lc_mode_e;

  localparam logic IDLE_LEVEL = 1'b1;
endpackage

// File: rtl/lc_mode_watch.sv
module lc_mode_watch
  import lc_pkg::*;
#(
  parameter int W = MODE_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] mode,
  output logic         changed
);
  logic [W-1:0] mode_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= '0;
    else        mode_q <= mode;
  end

  logic armed_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= 1'b1;
  end

  assign changed = armed_q && (mode != mode_q);
endmodule

// File: rtl/lc_tx_enc.sv
module lc_tx_enc
  import lc_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  lc_mode_e mode,
  input  logic     restart,
  input  logic     half_en,
  input  logic     in_valid,
  input  logic     in_bit,
  output logic     in_ready,
  output logic     line
);
  logic line_q, phase_q, second_q;
  logic first_lv, second_lv;

  assign in_ready = half_en && !phase_q && !restart;
  assign line     = line_q;

  always_comb begin
    first_lv  = in_bit;
    second_lv = in_bit;
    unique case (mode)
      LC_NRZB: begin
        first_lv  = ~in_bit;
        second_lv = ~in_bit;
      end
      LC_NRZI_M: begin
        first_lv  = in_bit ? ~line_q : line_q;
        second_lv = first_lv;
      end
      LC_NRZI_S: begin
        first_lv  = in_bit ? line_q : ~line_q;
        second_lv = first_lv;
      end
      LC_FM1: begin
        first_lv  = ~line_q;
        second_lv = in_bit ? ~first_lv : first_lv;
      end
      LC_FM0: begin
        first_lv  = ~line_q;
        second_lv = in_bit ? first_lv : ~first_lv;
      end
      LC_MANCH: begin
        first_lv  = in_bit;
        second_lv = ~in_bit;
      end
      default: begin
        first_lv  = in_bit;
        second_lv = in_bit;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q   <= IDLE_LEVEL;
      phase_q  <= 1'b0;
      second_q <= IDLE_LEVEL;
    end else if (restart) begin
      line_q  <= IDLE_LEVEL;
      phase_q <= 1'b0;
    end else if (half_en) begin
      if (phase_q) begin
        line_q  <= second_q;
        phase_q <= 1'b0;
      end else if (in_valid) begin
        line_q   <= first_lv;
        second_q <= second_lv;
        phase_q  <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/lc_rx_dec.sv
module lc_rx_dec
  import lc_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  lc_mode_e mode,
  input  logic     restart,
  input  logic     half_en,
  input  logic     line,
  output logic     out_valid,
  output logic     out_bit,
  output logic     out_viol
);
  logic phase_q, h1_q, ref_q;
  logic valid_q, bit_q, viol_q;
  logic dec_bit, dec_viol;

  always_comb begin
    dec_bit  = line;
    dec_viol = 1'b0;
    unique case (mode)
      LC_NRZB:   dec_bit = ~line;
      LC_NRZI_M: dec_bit = (line != ref_q);
      LC_NRZI_S: dec_bit = (line == ref_q);
      LC_FM1: begin
        dec_bit  = (h1_q != line);
        dec_viol = (h1_q == ref_q);
      end
      LC_FM0: begin
        dec_bit  = (h1_q == line);
        dec_viol = (h1_q == ref_q);
      end
      LC_MANCH: begin
        dec_bit  = h1_q;
        dec_viol = (h1_q == line);
      end
      default: dec_bit = line;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= 1'b0;
      h1_q    <= IDLE_LEVEL;
      ref_q   <= IDLE_LEVEL;
      valid_q <= 1'b0;
      bit_q   <= 1'b0;
      viol_q  <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      viol_q  <= 1'b0;
      if (restart) begin
        phase_q <= 1'b0;
        ref_q   <= IDLE_LEVEL;
      end else if (half_en) begin
        if (!phase_q) begin
          h1_q    <= line;
          phase_q <= 1'b1;
        end else begin
          phase_q <= 1'b0;
          ref_q   <= line;
          valid_q <= 1'b1;
          bit_q   <= dec_bit;
          viol_q  <= dec_viol;
        end
      end
    end
  end

  assign out_valid = valid_q;
  assign out_bit   = bit_q;
  assign out_viol  = viol_q;
endmodule

// File: rtl/lc_codec.sv
module lc_codec
  import lc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MODE_W-1:0] tx_mode,
  input  logic              tx_half_en,
  input  logic              tx_valid,
  input  logic              tx_data,
  output logic              tx_ready,
  output logic              tx_line,
  input  logic [MODE_W-1:0] rx_mode,
  input  logic              rx_half_en,
  input  logic              rx_line,
  output logic              rx_valid,
  output logic              rx_data,
  output logic              rx_viol
);
  logic tx_restart, rx_restart;

  lc_mode_watch #(.W(MODE_W)) tx_watch_i (
    .clk(clk), .rst_n(rst_n), .mode(tx_mode), .changed(tx_restart)
  );

  lc_mode_watch #(.W(MODE_W)) rx_watch_i (
    .clk(clk), .rst_n(rst_n), .mode(rx_mode), .changed(rx_restart)
  );

  lc_tx_enc tx_i (
    .clk(clk), .rst_n(rst_n), .mode(lc_mode_e'(tx_mode)), .restart(tx_restart),
    .half_en(tx_half_en), .in_valid(tx_valid), .in_bit(tx_data),
    .in_ready(tx_ready), .line(tx_line)
  );

  lc_rx_dec rx_i (
    .clk(clk), .rst_n(rst_n), .mode(lc_mode_e'(rx_mode)), .restart(rx_restart),
    .half_en(rx_half_en), .line(rx_line),
    .out_valid(rx_valid), .out_bit(rx_data), .out_viol(rx_viol)
  );
endmodule

// File: rtl/lc_codec_chk.sv
module lc_codec_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] tx_mode,
  input logic       tx_half_en,
  input logic       tx_valid,
  input logic       tx_data,
  input logic       tx_ready,
  input logic       tx_line,
  input logic [2:0] rx_mode,
  input logic       rx_half_en,
  input logic       rx_valid,
  input logic       rx_viol
);
  logic seen_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_q <= 1'b0;
    else        seen_q <= 1'b1;
  end

  AST_TX_RESTART_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && tx_mode != $past(tx_mode)) |=> tx_line) else $error("restart"); // R1

  AST_TX_READY_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> tx_half_en) else $error("ready"); // R2

  AST_TX_LINE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_half_en && (!seen_q || tx_mode == $past(tx_mode))) |=> $stable(tx_line)) else $error("hold"); // R2

  AST_TX_FM_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_ready && tx_valid && (tx_mode == 3'd4 || tx_mode == 3'd5))
      |=> tx_line != $past(tx_line)) else $error("fm"); // R5

  AST_TX_MANCH_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_ready && tx_valid && tx_mode == 3'd6) |=> tx_line == $past(tx_data)) else $error("manch"); // R6

  AST_RX_NO_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid) else $error("b2b"); // R7

  AST_RX_VALID_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && rx_valid) |-> $past(rx_half_en)) else $error("strobe"); // R7

  AST_RX_VIOL_BIPHASE: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && rx_viol) |-> (rx_valid && $past(rx_mode) >= 3'd4 && $past(rx_mode) <= 3'd6))
    else $error("viol"); // R8
endmodule

bind lc_codec lc_codec_chk chk_i (
  .clk(clk), .rst_n(rst_n), .tx_mode(tx_mode), .tx_half_en(tx_half_en),
  .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready), .tx_line(tx_line),
  .rx_mode(rx_mode), .rx_half_en(rx_half_en), .rx_valid(rx_valid), .rx_viol(rx_viol)
);

// File: tb/lc_codec_tb_top.sv
module lc_codec_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] tx_mode = 3'd0, rx_mode = 3'd0;
  logic tx_half_en = 0, tx_valid = 0, tx_data = 0, rx_half_en = 0, rx_line = 1;
  logic tx_ready, tx_line, rx_valid, rx_data, rx_viol;

  int total = 0, bad = 0;
  bit finished = 0;
  logic m_line = 1'b1;
  logic r_ref = 1'b1;

  always #10 clk = ~clk;

  lc_codec dut_i (
    .clk(clk), .rst_n(rst_n), .tx_mode(tx_mode), .tx_half_en(tx_half_en),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready), .tx_line(tx_line),
    .rx_mode(rx_mode), .rx_half_en(rx_half_en), .rx_line(rx_line),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_viol(rx_viol)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic logic m_first(input logic [2:0] m, input logic d, input logic l);
    case (m)
      3'd1: return ~d;
      3'd2: return d ? ~l : l;
      3'd3: return d ? l : ~l;
      3'd4, 3'd5: return ~l;
      3'd6: return d;
      default: return d;
    endcase
  endfunction

  function automatic logic m_second(input logic [2:0] m, input logic d, input logic f);
    case (m)
      3'd4: return d ? ~f : f;
      3'd5: return d ? f : ~f;
      3'd6: return ~d;
      default: return f;
    endcase
  endfunction

  function automatic string req_of(input logic [2:0] m);
    case (m)
      3'd2, 3'd3: return "R4";
      3'd4, 3'd5: return "R5";
      3'd6: return "R6";
      default: return "R3";
    endcase
  endfunction

  function automatic logic d_bit(input logic [2:0] m, input logic h1, input logic h2, input logic r);
    case (m)
      3'd1: return ~h2;
      3'd2: return h2 ^ r;
      3'd3: return ~(h2 ^ r);
      3'd4: return h1 ^ h2;
      3'd5: return ~(h1 ^ h2);
      3'd6: return h1;
      default: return h2;
    endcase
  endfunction

  function automatic logic d_viol(input logic [2:0] m, input logic h1, input logic h2, input logic r);
    case (m)
      3'd4, 3'd5: return h1 == r;
      3'd6: return h1 == h2;
      default: return 1'b0;
    endcase
  endfunction

  task automatic set_tx_mode(input logic [2:0] m);
    @(negedge clk); tx_mode = m;
    @(negedge clk);
    chk(tx_line === 1'b1, "R1", int'(tx_line), 1);
    m_line = 1'b1;
  endtask

  task automatic set_rx_mode(input logic [2:0] m);
    @(negedge clk); rx_mode = m;
    @(negedge clk);
    r_ref = 1'b1;
  endtask

  task automatic tx_bit(input logic d, input int gap, input bit poke_rx);
    logic f, s;
    f = m_first(tx_mode, d, m_line);
    s = m_second(tx_mode, d, f);
    @(negedge clk); tx_half_en = 1; tx_valid = 1; tx_data = d;
    #1 chk(tx_ready === 1'b1, "R2", int'(tx_ready), 1);
    @(negedge clk); tx_half_en = 0; tx_valid = 0;
    chk(tx_line === f, req_of(tx_mode), int'(tx_line), int'(f));
    if (poke_rx) begin
      rx_mode = rx_mode ^ 3'd1; r_ref = 1'b1;
    end
    for (int g = 0; g < gap; g++) begin
      @(negedge clk);
      chk(tx_line === f, "R2", int'(tx_line), int'(f));
    end
    tx_half_en = 1; tx_valid = 1; tx_data = ~d;
    #1 chk(tx_ready === 1'b0, "R2", int'(tx_ready), 0);
    @(negedge clk); tx_half_en = 0; tx_valid = 0;
    chk(tx_line === s, poke_rx ? "R9" : req_of(tx_mode), int'(tx_line), int'(s));
    m_line = s;
  endtask

  task automatic rx_bit(input logic h1, input logic h2);
    logic eb, ev;
    eb = d_bit(rx_mode, h1, h2, r_ref);
    ev = d_viol(rx_mode, h1, h2, r_ref);
    @(negedge clk); rx_half_en = 1; rx_line = h1;
    @(negedge clk); rx_half_en = 0;
    chk(rx_valid === 1'b0, "R7", int'(rx_valid), 0);
    rx_half_en = 1; rx_line = h2;
    @(negedge clk); rx_half_en = 0;
    chk(rx_valid === 1'b1, "R7", int'(rx_valid), 1);
    chk(rx_data === eb, "R7", int'(rx_data), int'(eb));
    chk(rx_viol === ev, "R8", int'(rx_viol), int'(ev));
    @(negedge clk);
    chk(rx_valid === 1'b0, "R7", int'(rx_valid), 0);
    r_ref = h2;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk(tx_line === 1'b1, "R1", int'(tx_line), 1);
    chk(rx_valid === 1'b0, "R7", int'(rx_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(tx_ready === 1'b0, "R2", int'(tx_ready), 0);

    // R3 NRZ, inverted NRZ, reserved code
    tx_bit(1'b0, 0, 0); tx_bit(1'b1, 1, 0);
    set_tx_mode(3'd1); tx_bit(1'b1, 0, 0); tx_bit(1'b0, 2, 0);
    set_tx_mode(3'd7); tx_bit(1'b0, 0, 0); tx_bit(1'b1, 0, 0);
    // R4 both NRZI flavours
    set_tx_mode(3'd2); tx_bit(1'b1, 0, 0); tx_bit(1'b0, 0, 0); tx_bit(1'b1, 1, 0);
    set_tx_mode(3'd3); tx_bit(1'b0, 0, 0); tx_bit(1'b0, 0, 0); tx_bit(1'b1, 0, 0);
    // R5 biphase with and without mid transitions
    set_tx_mode(3'd4); tx_bit(1'b1, 0, 0); tx_bit(1'b0, 0, 0); tx_bit(1'b0, 0, 0);
    set_tx_mode(3'd5); tx_bit(1'b1, 0, 0); tx_bit(1'b0, 1, 0);
    // R2 idle strobe at bit start holds the line
    @(negedge clk); tx_half_en = 1; tx_valid = 0;
    @(negedge clk); tx_half_en = 0;
    chk(tx_line === m_line, "R2", int'(tx_line), int'(m_line));
    tx_bit(1'b1, 0, 0);
    // R9 rx code change in mid-bit leaves tx alone
    tx_bit(1'b0, 1, 1);
    // R6 Manchester, then mode change mid-bit (R1)
    set_tx_mode(3'd6); tx_bit(1'b1, 0, 0); tx_bit(1'b0, 0, 0);
    @(negedge clk); tx_half_en = 1; tx_valid = 1; tx_data = 1;
    @(negedge clk); tx_half_en = 0; tx_valid = 0;
    set_tx_mode(3'd4);
    tx_bit(1'b1, 0, 0);

    // receive directed
    set_rx_mode(3'd0); rx_bit(1'b1, 1'b1); rx_bit(1'b0, 1'b0);
    set_rx_mode(3'd1); rx_bit(1'b1, 1'b1);
    set_rx_mode(3'd2); rx_bit(1'b0, 1'b0); rx_bit(1'b0, 1'b0);
    set_rx_mode(3'd3); rx_bit(1'b1, 1'b1); rx_bit(1'b0, 1'b0);
    set_rx_mode(3'd4); rx_bit(1'b0, 1'b1); rx_bit(1'b0, 1'b0); rx_bit(1'b0, 1'b1);
    set_rx_mode(3'd5); rx_bit(1'b0, 1'b0); rx_bit(1'b1, 1'b1);
    set_rx_mode(3'd6); rx_bit(1'b1, 1'b0); rx_bit(1'b0, 1'b0);
    // R1 rx reference back to 1: first half low is no violation
    set_rx_mode(3'd4); rx_bit(1'b0, 1'b0);
    set_rx_mode(3'd5); rx_bit(1'b1, 1'b0);

    // random mix
    for (int i = 0; i < 150; i++) begin
      logic [2:0] m;
      m = 3'($urandom % 8);
      if (m != tx_mode) set_tx_mode(m);
      tx_bit(1'($urandom % 2), int'($urandom % 3), 0);
    end
    for (int i = 0; i < 150; i++) begin
      logic [2:0] m;
      m = 3'($urandom % 8);
      if (($urandom % 4) == 0 && m != rx_mode) set_rx_mode(m);
      rx_bit(1'($urandom % 2), 1'($urandom % 2));
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule